// File: doc/BRIEF.md
# Modified Miller Reader-Frame Encoder

This block converts a reader-to-card frame into a pause-request line for a carrier modulator. It runs on the 13.56 MHz carrier clock. One symbol lasts a fixed number of carrier cycles. Each symbol is one of three kinds: a pause at the start, a pause at mid-period, or no pause at all. Which kind a logic 0 takes depends on the symbol sent before it.

A frame begins with a start pulse, which also latches a frame kind and a data-bit count. The kind is short, standard, or the reader half of a split anticollision frame. Payload bytes are then pulled one at a time through a valid/ready handshake while the frame is on air. The block adds the start-of-frame symbol, the odd parity bits and the end-of-frame pair by itself. The `pause` output is high for every carrier cycle in which the modulator must cut the field. `busy` covers the whole frame, and `done` marks its end.

Top module: `pcd_miller_enc`

## Requirements
- R1: Every symbol occupies exactly BIT_CYC (default 128) carrier cycles, and symbols follow one another with no gap; the first symbol begins on the clock edge that accepts the start.
- R2: The frame opens with a start symbol that has a pause at the beginning of the period, so `pause` is high in the 1st to 28th cycle after the accepting edge.
- R3: A logic 1 has its pause starting BIT_CYC/2 cycles into the symbol, and there is no pause elsewhere in that symbol.
- R4: Every pause lasts exactly PAUSE_CYC (default 28) cycles.
- R5: A logic 0 that follows a logic 1 has no pause at all. A logic 0 that follows a logic 0, or that is the first bit after the start symbol, has its pause at the beginning of the period. The rule applies to parity bits as well.
- R6: The frame closes with a logic 0 coded by the rule of R5, followed by one symbol with no pause.
- R7: With `frame_type` = 2'b00 (short), exactly 7 bits are sent: bits 0 to 6 of the first byte, least significant first. No parity is sent, and `bit_count` is ignored.
- R8: With `frame_type` = 2'b01 (standard), the data bits go least significant first, and each byte is followed by an odd parity bit, which is 1 when the byte holds an even number of ones.
- R9: With `frame_type` = 2'b10 (split), `bit_count` data bits are sent. Each complete byte is followed by parity. A final partial byte is not, so a split on a byte boundary ends with a parity bit and any other split does not.
- R10: A byte moves only on a cycle with `in_valid` and `in_ready` both high. `in_ready` is low while idle. Exactly ceil(n/8) bytes are taken for an n-bit frame, and extra offered bytes are left alone.
- R11: A start is accepted only while idle. A start raised during a frame has no effect on that frame's output.
- R12: After reset, `busy`, `done`, `pause` and `in_ready` are low. `busy` is high from the accepting edge for BIT_CYC times the symbol count, and `done` is high for exactly the one cycle in which `busy` first reads low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a frame (accepted while idle) |
| frame_type | input | 2 | 00 short, 01 standard, 10 split reader half |
| bit_count | input | CNT_W | Number of data bits (standard and split) |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte offered |
| in_ready | output | 1 | Encoder will take a byte this cycle |
| pause | output | 1 | High while the carrier must be paused |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The case hardest to reach from the ports is a frame in which parity bits and runs of zeros interact. A parity value becomes the history bit for the next data bit, and a zero run that starts right after the start symbol has to keep the beginning-pause coding all the way through. Payloads such as 0x00 bytes, bytes with even weight, and split counts both on and off byte boundaries drive the encoder into those transitions. A behavioural model expands each frame into its per-cycle pause pattern and compares it with the outputs on every clock. A start pulsed in the middle of a frame and extra payload bytes offered at the handshake show that neither one changes what is sent.

// File: rtl/miller_pkg.sv
package miller_pkg;
  typedef enum logic [1:0] {
    FT_SHORT = 2'b00,
    FT_STD   = 2'b01,
    FT_SPLIT = 2'b10,
    FT_RSVD  = 2'b11
  } frame_t;

  typedef enum logic [1:0] {
    SC_NONE  = 2'b00,
    SC_MID   = 2'b01,
    SC_EARLY = 2'b10
  } sym_code_t;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_SOF  = 3'd1,
    S_DATA = 3'd2,
    S_PAR  = 3'd3,
    S_EOF0 = 3'd4,
    S_EOF1 = 3'd5
  } seq_st_t;
endpackage

// File: rtl/miller_frame_seq.sv
module miller_frame_seq
  import miller_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        frame_type,
  input  logic [CNT_W-1:0]  bit_count,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              sym_end,
  output logic              in_ready,
  output logic              start_acc,
  output logic              busy,
  output logic              done,
  output logic              nxt_bit,
  output logic              nxt_blank
);
  localparam int IDX_W = $clog2(BYTE_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BYTE_W - 1);
  localparam int SHORT_BITS = 7;

  seq_st_t              st, st_n;
  frame_t               ft_q;
  logic [CNT_W-1:0]     total_q, bit_no, fetch_left;
  logic [IDX_W-1:0]     bib, bib_inc;
  logic [BYTE_W-1:0]    shreg, bbuf, cur_buf;
  logic                 bbuf_vld;
  logic                 par_en, load_byte, step_bit, take, last_bit;
  logic [CNT_W-1:0]     total_in, fetch_in;

  assign start_acc = start && (st == S_IDLE);
  assign busy      = (st != S_IDLE);
  assign in_ready  = busy && !bbuf_vld && (fetch_left != '0);
  assign take      = in_valid && in_ready;
  assign par_en    = (ft_q != FT_SHORT);
  assign bib_inc   = bib + IDX_W'(1);
  assign cur_buf   = bbuf_vld ? bbuf : '0;
  assign last_bit  = (bit_no == total_q - CNT_W'(1));
  assign total_in  = (frame_t'(frame_type) == FT_SHORT) ? CNT_W'(SHORT_BITS) : bit_count;
  assign fetch_in  = (total_in + CNT_W'(BYTE_W - 1)) / CNT_W'(BYTE_W);

  always_comb begin
    st_n      = st;
    nxt_bit   = 1'b0;
    nxt_blank = 1'b0;
    load_byte = 1'b0;
    step_bit  = 1'b0;
    case (st)
      S_SOF: begin
        st_n      = S_DATA;
        load_byte = 1'b1;
        nxt_bit   = cur_buf[0];
      end
      S_DATA: begin
        if (bib == IDX_LAST && par_en) begin
          st_n    = S_PAR;
          nxt_bit = ~^shreg;
        end else if (last_bit) begin
          st_n    = S_EOF0;
        end else begin
          st_n     = S_DATA;
          step_bit = 1'b1;
          if (bib == IDX_LAST) begin
            load_byte = 1'b1;
            nxt_bit   = cur_buf[0];
          end else begin
            nxt_bit = shreg[bib_inc];
          end
        end
      end
      S_PAR: begin
        if (last_bit) begin
          st_n = S_EOF0;
        end else begin
          st_n      = S_DATA;
          step_bit  = 1'b1;
          load_byte = 1'b1;
          nxt_bit   = cur_buf[0];
        end
      end
      S_EOF0: begin
        st_n      = S_EOF1;
        nxt_blank = 1'b1;
      end
      S_EOF1: begin
        st_n      = S_IDLE;
        nxt_blank = 1'b1;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      ft_q       <= FT_SHORT;
      total_q    <= '0;
      bit_no     <= '0;
      bib        <= '0;
      shreg      <= '0;
      bbuf       <= '0;
      bbuf_vld   <= 1'b0;
      fetch_left <= '0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start_acc) begin
        st         <= S_SOF;
        ft_q       <= frame_t'(frame_type);
        total_q    <= total_in;
        bit_no     <= '0;
        bib        <= '0;
        bbuf_vld   <= 1'b0;
        fetch_left <= fetch_in;
      end else if (sym_end) begin
        st <= st_n;
        if (step_bit) begin
          bit_no <= bit_no + CNT_W'(1);
          bib    <= bib_inc;
        end
        if (load_byte) begin
          shreg    <= cur_buf;
          bbuf_vld <= 1'b0;
        end
        if (st == S_EOF1) done <= 1'b1;
      end
      if (take) begin
        bbuf       <= in_data;
        bbuf_vld   <= 1'b1;
        fetch_left <= fetch_left - CNT_W'(1);
      end
    end
  end

  // R7: a short frame never reaches a parity symbol
  p_short_no_par_r7: assert property (@(posedge clk) disable iff (rst)
    (st == S_PAR) |-> (ft_q != FT_SHORT));

  // R10: no byte is taken while idle
  p_ready_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !in_ready);
endmodule

// File: rtl/miller_sym_map.sv
module miller_sym_map
  import miller_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start_acc,
  input  logic      sym_end,
  input  logic      nxt_bit,
  input  logic      nxt_blank,
  output sym_code_t code
);
  logic prev_one;

  always_ff @(posedge clk) begin
    if (rst) begin
      code     <= SC_NONE;
      prev_one <= 1'b0;
    end else if (start_acc) begin
      code     <= SC_EARLY;
      prev_one <= 1'b0;
    end else if (sym_end) begin
      if (nxt_blank) begin
        code <= SC_NONE;
      end else if (nxt_bit) begin
        code     <= SC_MID;
        prev_one <= 1'b1;
      end else begin
        code     <= prev_one ? SC_NONE : SC_EARLY;
        prev_one <= 1'b0;
      end
    end
  end

  // R5: two mid-period symbols in a row cannot be separated by a zero coded early
  p_code_legal_r5: assert property (@(posedge clk) disable iff (rst)
    (sym_end && !start_acc && !nxt_blank && !nxt_bit && prev_one) |=> (code == SC_NONE));
endmodule

// File: rtl/miller_pause_gen.sv
module miller_pause_gen
  import miller_pkg::*;
#(
  parameter int BIT_CYC   = 128,
  parameter int PAUSE_CYC = 28
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      busy,
  input  logic      start_acc,
  input  sym_code_t code,
  output logic      sym_end,
  output logic      pause
);
  localparam int CW = $clog2(BIT_CYC + 1);
  localparam logic [CW-1:0] C_LAST  = CW'(BIT_CYC - 1);
  localparam logic [CW-1:0] C_HALF  = CW'(BIT_CYC / 2);
  localparam logic [CW-1:0] C_PW    = CW'(PAUSE_CYC);
  localparam logic [CW-1:0] C_MIDE  = CW'(BIT_CYC / 2 + PAUSE_CYC);

  logic [CW-1:0] cnt, run_q;
  logic          want;

  assign sym_end = busy && (cnt == C_LAST);
  assign want = busy && (((code == SC_EARLY) && (cnt < C_PW)) ||
                         ((code == SC_MID) && (cnt >= C_HALF) && (cnt < C_MIDE)));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      pause <= 1'b0;
      run_q <= '0;
    end else begin
      if (start_acc)    cnt <= '0;
      else if (busy)    cnt <= (cnt == C_LAST) ? '0 : cnt + CW'(1);
      pause <= want;
      run_q <= pause ? run_q + CW'(1) : '0;
    end
  end

  // R4: a pause never runs beyond its width
  p_pause_max_r4: assert property (@(posedge clk) disable iff (rst)
    pause |-> (run_q < C_PW));
  // R4: a pause that ends has lasted its full width
  p_pause_min_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(pause) |-> (run_q == C_PW));
endmodule

// File: rtl/pcd_miller_enc.sv
module pcd_miller_enc
  import miller_pkg::*;
#(
  parameter int BIT_CYC   = 128,
  parameter int PAUSE_CYC = 28,
  parameter int CNT_W     = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       frame_type,
  input  logic [CNT_W-1:0] bit_count,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             pause,
  output logic             busy,
  output logic             done
);
  logic      start_acc, sym_end, nxt_bit, nxt_blank;
  sym_code_t code;

  miller_frame_seq #(.CNT_W(CNT_W), .BYTE_W(8)) u_seq (
    .clk(clk), .rst(rst), .start(start), .frame_type(frame_type),
    .bit_count(bit_count), .in_data(in_data), .in_valid(in_valid),
    .sym_end(sym_end), .in_ready(in_ready), .start_acc(start_acc),
    .busy(busy), .done(done), .nxt_bit(nxt_bit), .nxt_blank(nxt_blank)
  );

  miller_sym_map u_map (
    .clk(clk), .rst(rst), .start_acc(start_acc), .sym_end(sym_end),
    .nxt_bit(nxt_bit), .nxt_blank(nxt_blank), .code(code)
  );

  miller_pause_gen #(.BIT_CYC(BIT_CYC), .PAUSE_CYC(PAUSE_CYC)) u_pg (
    .clk(clk), .rst(rst), .busy(busy), .start_acc(start_acc),
    .code(code), .sym_end(sym_end), .pause(pause)
  );

  // R12: done lasts a single cycle
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R12: done coincides with busy dropping
  p_done_at_end_r12: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  // R2: the start symbol pauses right away
  p_sof_early_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> pause);
endmodule

// File: tb/sim_pcd_miller_enc.sv
module sim_pcd_miller_enc;
  localparam int BIT = 128;
  localparam int PW  = 28;
  localparam int CW  = 12;

  logic          clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [1:0]    ftype = 2'b00;
  logic [CW-1:0] nbits = '0;
  logic [7:0]    in_data = 8'h00;
  logic          in_valid = 1'b0;
  logic          in_ready, pause, busy, done;

  pcd_miller_enc #(.BIT_CYC(BIT), .PAUSE_CYC(PW), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .start(start), .frame_type(ftype), .bit_count(nbits),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .pause(pause), .busy(busy), .done(done)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0, bcnt = 0, consumed = 0;
  logic [7:0] frm_bytes[$];
  logic [7:0] feed_q[$];
  bit exp_q[$];
  bit e_pause = 0, e_busy = 0, e_done = 0;

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // codes: 0 no pause, 1 mid pause, 2 early pause
  function automatic void build(input int ft, input int nb);
    bit bits[$];
    int codes[$];
    bit prev;
    int ones;
    if (ft == 0) begin
      for (int i = 0; i < 7; i++) bits.push_back(frm_bytes[0][i]);
    end else begin
      for (int i = 0; i < nb; i++) begin
        bits.push_back(frm_bytes[i/8][i%8]);
        if (i % 8 == 7) begin
          ones = 0;
          for (int k = 0; k < 8; k++) ones += frm_bytes[i/8][k];
          bits.push_back((ones % 2) == 0);
        end
      end
    end
    codes.push_back(2);
    prev = 0;
    foreach (bits[j]) begin
      codes.push_back(bits[j] ? 1 : (prev ? 0 : 2));
      prev = bits[j];
    end
    codes.push_back(prev ? 0 : 2);
    codes.push_back(0);
    foreach (codes[j])
      for (int p = 0; p < BIT; p++)
        exp_q.push_back((codes[j] == 2 && p < PW) ||
                        (codes[j] == 1 && p >= BIT/2 && p < BIT/2 + PW));
    bcnt = BIT * codes.size();
  endfunction

  // reference model, advanced on every clock
  always @(posedge clk) begin
    if (rst) begin
      exp_q.delete(); bcnt = 0; e_pause = 0; e_busy = 0; e_done = 0;
    end else begin
      bit was;
      was = (bcnt > 0);
      e_pause = (exp_q.size() > 0) ? exp_q.pop_front() : 1'b0;
      e_done = (bcnt == 1);
      if (bcnt > 0) bcnt--;
      if (start && !was) build(int'(ftype), int'(nbits));
      e_busy = (bcnt > 0);
    end
  end

  always @(posedge clk) begin
    if (!rst && in_valid && in_ready) begin
      void'(feed_q.pop_front());
      consumed++;
    end
  end

  always @(negedge clk) begin
    in_valid = (feed_q.size() > 0);
    in_data  = (feed_q.size() > 0) ? feed_q[0] : 8'h00;
    if (!rst) begin
      chk("R1 R2 R3 R4 R5 R6 R7 R8 R9 pause", pause, e_pause);
      chk("R12 busy", busy, e_busy);
      chk("R12 done", done, e_done);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<150000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic run_frame(input int ft, input int nb, input int need,
                           input logic [7:0] b[$], input bit poke);
    frm_bytes = b;
    feed_q    = b;
    consumed  = 0;
    @(negedge clk);
    start = 1'b1; ftype = 2'(ft); nbits = CW'(nb);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R11: a start during the frame with different settings must be ignored
      repeat (300) @(negedge clk);
      start = 1'b1; ftype = 2'b01; nbits = CW'(16);
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk_int("R10 bytes taken", consumed, need);
    feed_q.delete();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 reset pause", pause, 1'b0);
    chk("R12 reset busy", busy, 1'b0);
    chk("R12 reset done", done, 1'b0);
    chk("R10 reset ready", in_ready, 1'b0);
    // R7: short frame, bit_count value ignored
    run_frame(0, 50, 1, '{8'h26}, 0);
    run_frame(0, 3, 1, '{8'h52}, 0);
    // R8: standard frames, including zero runs and even-weight bytes
    run_frame(1, 16, 2, '{8'h93, 8'h20}, 0);
    run_frame(1, 24, 3, '{8'h00, 8'h00, 8'hFF}, 0);
    // R9: split off a byte boundary, extra byte offered (R10)
    run_frame(2, 20, 3, '{8'h93, 8'h41, 8'h0A, 8'h55}, 0);
    // R9: split on a byte boundary
    run_frame(2, 24, 3, '{8'h93, 8'h30, 8'h01}, 0);
    // R11: start pulsed mid-frame
    run_frame(1, 16, 2, '{8'h00, 8'h81}, 1);
    // R3 R5: alternating ones and zeros
    run_frame(2, 17, 3, '{8'hA5, 8'h5A, 8'h01}, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule